// File: doc/BRIEF.md
# XOR-Popcount Engine for Binary Network Layers

The engine measures how far apart two binary vectors are. Each vector holds N words of 32 bits, and each bit stands for a value of -1 or +1. The product of two such values is +1 when the bits agree and -1 when they differ, so the XOR of the two words marks every position that gives a -1 product. Host logic loads the two operand vectors through a single write port into two small word memories, one for each operand. It then pulses `start`.

The computation has four phases. First, every lane replaces its word with the XOR of its two operands and clears its 6-bit count. Next, every lane runs 32 passes in parallel. Each pass adds the lowest bit of the lane word (the word ANDed with a mask of 1) to the lane count, then shifts the word right by one with a zero entering at the top. Third, the lane counts are added into the total one lane per cycle. Last, a one-cycle `done` pulse is given. At that point `total` holds the number of differing bits, and `dot` holds the signed ±1 dot product, 32·N − 2·total.

The controller has five states:
- IDLE: waiting for a start.
- COMBINE: loads the XOR words and clears the counts and the total.
- SCAN: the 32 mask-and-shift passes.
- SUM: the serial reduction over the lanes.
- FINISH: the `done` cycle.

The transitions are:
- launch: IDLE→COMBINE, and also FINISH→COMBINE, on `start`.
- scan-entry: COMBINE→SCAN, always.
- scan-exit: SCAN→SUM, after the 32nd pass.
- sum-exit: SUM→FINISH, after the last lane.
- retire: FINISH→IDLE, when there is no `start`.

Top module: `bnn_xpop_engine`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `total` is 0.
- R2: A write with `wr_en` high while `busy` is low stores `wr_data` into word `wr_addr` of operand A when `wr_sel` is 0, and of operand B when `wr_sel` is 1. A write made while `busy` is high has no effect on any later result.
- R3: `start` is accepted only while `busy` is low, and `busy` rises in the next cycle. A `start` given while `busy` is high has no effect on the run in progress or on its result.
- R4: At `done`, `total` equals the sum over all lanes i of the number of set bits in A[i] XOR B[i].
- R5: After an accepted `start`, `busy` stays high for exactly 33+N cycles, and `done` is high in the cycle that follows them.
- R6: `done` is a single-cycle pulse, and `busy` and `done` are never high together.
- R7: While `done` is high, `dot` equals 32·N − 2·`total`, as a signed two's-complement value.
- R8: While `busy` is low and no `start` is accepted, `total` holds its last value.
- R9: Every one of the 32 bit positions counts, including bit 31. This is shown by a lane with all 32 bits differing, which gives 32 without wrap-around, and by a lane with only the top bit differing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 1 | 0 selects operand A, 1 selects operand B |
| wr_addr | input | IW | Word (lane) index for the write |
| wr_data | input | 32 | Word to store |
| start | input | 1 | Launch pulse |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| total | output | TW | Count of differing bits over all lanes |
| dot | output | TW+1 | Signed ±1 dot product, 32·N − 2·total |

## Verification
The engine is run with these operand patterns:
- All zeros and identical operands, which must give a zero count.
- Fully complementary operands, which give the maximum count and the most negative dot product.
- A lone top bit and a lone bottom bit in single lanes, which tell a correct logical shift and full pass count apart from an off-by-one in the number of passes.
- Alternating bit patterns and pseudo-random words, which catch errors in the lane-to-sum reduction and in lane indexing.

Writes and starts issued mid-run check that both are ignored. A restart given in the `done` cycle checks the FINISH→COMBINE path.

// File: rtl/bnn_xpop_pkg.sv
package bnn_xpop_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COMBINE = 3'd1,
        ST_SCAN    = 3'd2,
        ST_SUM     = 3'd3,
        ST_FINISH  = 3'd4
    } xpop_state_t;
endpackage

// File: rtl/bnn_opmem.sv
module bnn_opmem #(
    parameter int N  = 8,
    parameter int WW = 32,
    parameter int IW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     addr,
    input  logic [WW-1:0]     wdata,
    output logic [N*WW-1:0]   words
);
    for (genvar g = 0; g < N; g++) begin : g_word
        logic [WW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (addr == IW'(g))) begin
                word_q <= wdata;
            end
        end
        assign words[g*WW +: WW] = word_q;
    end
endmodule

// File: rtl/bnn_lane.sv
module bnn_lane #(
    parameter int WW = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [WW-1:0] op_a,
    input  logic [WW-1:0] op_b,
    output logic [CW-1:0] count
);
    localparam logic [WW-1:0] MASK = WW'(1);

    logic [WW-1:0] diff_q;
    logic [CW-1:0] cnt_q;
    logic [WW-1:0] masked;

    assign masked = diff_q & MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            diff_q <= op_a ^ op_b;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + CW'(masked);
            diff_q <= diff_q >> 1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/bnn_reduce.sv
module bnn_reduce #(
    parameter int N  = 8,
    parameter int CW = 6,
    parameter int TW = 9,
    parameter int IW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            step,
    input  logic [IW-1:0]   idx,
    input  logic [N*CW-1:0] counts,
    output logic [TW-1:0]   sum
);
    logic [CW-1:0] picked;
    logic [TW-1:0] sum_q;

    always_comb begin
        picked = '0;
        for (int k = 0; k < N; k++) begin
            if (idx == IW'(k)) picked = counts[k*CW +: CW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clr) begin
            sum_q <= '0;
        end else if (step) begin
            sum_q <= sum_q + TW'(picked);
        end
    end

    assign sum = sum_q;
endmodule

// File: rtl/bnn_xpop_engine.sv
module bnn_xpop_engine
    import bnn_xpop_pkg::*;
#(
    parameter int N  = 8,
    parameter int WW = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1,
    parameter int TW = $clog2(WW * N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [IW-1:0]        wr_addr,
    input  logic [WW-1:0]        wr_data,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    output logic [TW-1:0]        total,
    output logic signed [TW:0]   dot
);
    localparam int CW   = $clog2(WW + 1);
    localparam int PW   = $clog2(WW);
    localparam int FULL = WW * N;

    xpop_state_t state_q, state_d;
    logic [PW-1:0] pass_q;
    logic [IW-1:0] lane_q;
    logic [N*WW-1:0] a_words, b_words;
    logic [N*CW-1:0] lane_counts;
    logic we_a, we_b, lane_load, lane_step, sum_clr, sum_step;

    assign we_a = wr_en && !busy && !wr_sel;
    assign we_b = wr_en && !busy &&  wr_sel;

    bnn_opmem #(.N(N), .WW(WW), .IW(IW)) u_mem_a (
        .clk(clk), .rst_n(rst_n), .we(we_a), .addr(wr_addr),
        .wdata(wr_data), .words(a_words)
    );
    bnn_opmem #(.N(N), .WW(WW), .IW(IW)) u_mem_b (
        .clk(clk), .rst_n(rst_n), .we(we_b), .addr(wr_addr),
        .wdata(wr_data), .words(b_words)
    );

    for (genvar g = 0; g < N; g++) begin : g_lane
        bnn_lane #(.WW(WW), .CW(CW)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(lane_load), .step(lane_step),
            .op_a(a_words[g*WW +: WW]), .op_b(b_words[g*WW +: WW]),
            .count(lane_counts[g*CW +: CW])
        );
    end

    bnn_reduce #(.N(N), .CW(CW), .TW(TW), .IW(IW)) u_reduce (
        .clk(clk), .rst_n(rst_n), .clr(sum_clr), .step(sum_step),
        .idx(lane_q), .counts(lane_counts), .sum(total)
    );

    // state register and pass / lane counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pass_q  <= '0;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_COMBINE) begin
                pass_q <= '0;
                lane_q <= '0;
            end else if (state_q == ST_SCAN) begin
                pass_q <= pass_q + PW'(1);
            end else if (state_q == ST_SUM) begin
                lane_q <= lane_q + IW'(1);
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_COMBINE;
            ST_COMBINE: state_d = ST_SCAN;
            ST_SCAN:    if (pass_q == PW'(WW - 1)) state_d = ST_SUM;
            ST_SUM:     if (lane_q == IW'(N - 1)) state_d = ST_FINISH;
            ST_FINISH:  state_d = start ? ST_COMBINE : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        lane_load = 1'b0;
        lane_step = 1'b0;
        sum_clr   = 1'b0;
        sum_step  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_COMBINE: begin busy = 1'b1; lane_load = 1'b1; sum_clr = 1'b1; end
            ST_SCAN:    begin busy = 1'b1; lane_step = 1'b1; end
            ST_SUM:     begin busy = 1'b1; sum_step = 1'b1; end
            ST_FINISH:  done = 1'b1;
            default:    ;
        endcase
    end

    assign dot = $signed((TW + 1)'(FULL)) - $signed({total, 1'b0});
endmodule

// File: rtl/bnn_xpop_checker.sv
module bnn_xpop_checker #(
    parameter int N  = 8,
    parameter int WW = 32,
    parameter int TW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [TW-1:0] total
);
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r3_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
    a_r8_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(total));
    a_r9_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
        total <= TW'(WW * N));
endmodule

bind bnn_xpop_engine bnn_xpop_checker #(.N(N), .WW(WW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .total(total)
);

// File: tb/sim_bnn_xpop_engine.sv
module sim_bnn_xpop_engine;
    localparam int N  = 8;
    localparam int WW = 32;
    localparam int IW = 3;
    localparam int TW = $clog2(WW * N + 1);
    localparam int LAST = 34 + N;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, wr_sel = 0, start = 0;
    logic [IW-1:0] wr_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic busy, done;
    logic [TW-1:0] total;
    logic signed [TW:0] dot;

    int compared = 0, mismatched = 0;
    int t = 0;
    int last_total = 0;
    logic [WW-1:0] ra [N];
    logic [WW-1:0] rb [N];

    always #10 clk = ~clk;

    bnn_xpop_engine #(.N(N), .WW(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
        .busy(busy), .done(done), .total(total), .dot(dot)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_sum();
        int s = 0;
        for (int i = 0; i < N; i++) s += $countones(ra[i] ^ rb[i]);
        return s;
    endfunction

    // reference model (R2, R3, R5)
    always @(posedge clk) begin
        if (!rst_n) begin
            t <= 0;
            for (int i = 0; i < N; i++) begin ra[i] <= '0; rb[i] <= '0; end
        end else begin
            if ((t == 0 || t == LAST) && start) t <= 1;
            else if (t == LAST) t <= 0;
            else if (t != 0) t <= t + 1;
            if (wr_en && !(t >= 1 && t < LAST)) begin
                if (wr_sel) rb[wr_addr] <= wr_data;
                else        ra[wr_addr] <= wr_data;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            int s;
            bit eb, ed;
            eb = (t >= 1 && t < LAST);
            ed = (t == LAST);
            check(busy == eb, "R5 busy", int'(busy), int'(eb));
            check(done == ed, "R6 done", int'(done), int'(ed));
            if (ed) begin
                s = ref_sum();
                check(int'(total) == s, "R4 total", int'(total), s);
                check(int'(dot) == WW * N - 2 * s, "R7 dot", int'(dot), WW * N - 2 * s);
                last_total = s;
            end else if (t == 0) begin
                check(int'(total) == last_total, "R8 hold", int'(total), last_total);
            end
        end
    end

    task automatic put(input bit sel, input int addr, input logic [WW-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_addr = IW'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic fill(input logic [WW-1:0] a, input logic [WW-1:0] b);
        for (int i = 0; i < N; i++) begin put(0, i, a); put(1, i, b); end
    endtask

    task automatic run();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(busy == 0 && done == 0 && total == 0, "R1 reset", int'(total), 0);

        fill('0, '0); run();                               // R4 zeros
        fill(32'hFFFF_FFFF, 32'h0); run();                 // R9 full lanes, R7 minimum
        fill(32'h1234_5678, 32'h1234_5678); run();         // R4 equal operands
        fill('0, '0); put(0, 5, 32'h8000_0000); run();     // R9 top bit only
        fill('0, '0); put(1, 0, 32'h0000_0001); run();     // R9 bottom bit only
        fill(32'hAAAA_AAAA, 32'h5555_5555); run();         // R4 alternating
        for (int i = 0; i < N; i++) begin                   // R2 random words
            put(0, i, $urandom); put(1, i, $urandom);
        end
        run();

        // R2 write while busy ignored, R3 start while busy ignored
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        wr_en = 1; wr_sel = 0; wr_addr = 2; wr_data = 32'hDEAD_BEEF;
        @(negedge clk); wr_en = 0; start = 1;
        @(negedge clk); start = 0;
        while (!done) @(negedge clk);
        // R3 restart in the done cycle
        start = 1;
        @(negedge clk); start = 0;
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule